// File: doc/BRIEF.md
# Cascaded One-Hot Priority Grant Encoder

This block accepts a request vector of 4×N bits and returns a grant vector of the same width in which at most one bit is set, namely the bit of the asserted request with the lowest index. Bit 0 has the highest priority, and priority falls as the index rises. The grant vector and an any-request flag are both registered. They appear one clock after the request is sampled.

The logic is split into N identical four-bit groups. Each group ORs its own four requests into a group-active term and makes a local one-hot pick, where the first bit of the group wins. A serial "already claimed" chain runs from group 0 toward group N-1. It disables every group that lies below an active group, so the design grows by adding groups and never needs one flat priority loop.

Top module: `cas_prio_grant`

## Requirements
- R1: A synchronous reset, active high, clears the grant vector and the any-request flag to zero on the next rising clock edge.
- R2: Each cycle, the grant vector is registered as a one-hot copy of the lowest-index asserted request bit, or zero when no request is asserted. It is visible one clock after the request is sampled.
- R3: At most one grant bit is ever set.
- R4: A grant bit can be set only when the matching request bit was asserted in the previous cycle.
- R5: The any-request flag is one in the cycle after at least one request bit is asserted, and zero otherwise. A set flag always comes with exactly one grant bit.
- R6: Within a group, the first bit wins over the later three. A group receives no grant while any request bit in a lower-numbered group is asserted.
- R7: The width is 4×GROUPS with GROUPS ≥ 1, and the parameter is checked at elaboration. The default is GROUPS = 8, which gives 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4*GROUPS | Request vector; bit 0 has the highest priority |
| grant | output | 4*GROUPS | Registered one-hot grant |
| any_req | output | 1 | Registered flag: some request was asserted |

## Verification
The assertions check on every cycle that the grant is one-hot or zero, that no grant is given without a matching request in the previous cycle, and that the flag agrees with the grant and with the request. They also check that reset clears both outputs. Only the bench's scenarios can show that the chosen bit is the lowest-index one. Those scenarios cover the cases where a lower group suppresses a higher one: a single bit at each position, all-ones, all-zero, and random vectors with sparse and dense densities.

// File: rtl/cas_prio_pkg.sv
package cas_prio_pkg;
   localparam int unsigned SLICE_W = 4;
   typedef logic [SLICE_W-1:0] slice_vec_t;
endpackage

// File: rtl/cas_prio_slice.sv
module cas_prio_slice
   import cas_prio_pkg::*;
(
   input  slice_vec_t req_s,
   input  logic       claimed_in,
   output slice_vec_t pick_s,
   output logic       claimed_out
);
   logic grp_act;
   logic en;

   assign grp_act     = |req_s;
   assign en          = ~claimed_in;
   assign claimed_out = claimed_in | grp_act;

   always_comb begin
      pick_s[0] = req_s[0] & en;
      pick_s[1] = req_s[1] & ~req_s[0] & en;
      pick_s[2] = req_s[2] & ~req_s[1] & ~req_s[0] & en;
      pick_s[3] = req_s[3] & ~req_s[2] & ~req_s[1] & ~req_s[0] & en;
   end

   always_comb begin
      assert_slice_onehot_R6: assert ($onehot0(pick_s));
      if (claimed_in)
         assert_slice_muted_R6: assert (pick_s == '0);
   end
endmodule

// File: rtl/cas_prio_chain.sv
module cas_prio_chain
   import cas_prio_pkg::*;
#(
   parameter int unsigned GROUPS = 8,
   localparam int unsigned W = SLICE_W * GROUPS
) (
   input  logic [W-1:0] req,
   output logic [W-1:0] pick,
   output logic         any_hit
);
   logic [GROUPS:0] claim;
   assign claim[0] = 1'b0;

   for (genvar g = 0; g < GROUPS; g++) begin : g_slice
      cas_prio_slice u_slice (
         .req_s      (req[g*SLICE_W +: SLICE_W]),
         .claimed_in (claim[g]),
         .pick_s     (pick[g*SLICE_W +: SLICE_W]),
         .claimed_out(claim[g+1])
      );
   end

   assign any_hit = claim[GROUPS];
endmodule

// File: rtl/cas_prio_grant.sv
module cas_prio_grant
   import cas_prio_pkg::*;
#(
   parameter int unsigned GROUPS = 8,
   localparam int unsigned W = SLICE_W * GROUPS
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] req,
   output logic [W-1:0] grant,
   output logic         any_req
);
   if (GROUPS < 1) begin : g_bad_groups
      $error("cas_prio_grant: GROUPS must be at least 1 (R7)");
   end

   logic [W-1:0] pick_c;
   logic         hit_c;

   cas_prio_chain #(.GROUPS(GROUPS)) u_chain (
      .req    (req),
      .pick   (pick_c),
      .any_hit(hit_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         grant   <= '0;
         any_req <= 1'b0;
      end else begin
         grant   <= pick_c;
         any_req <= hit_c;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (grant == '0 && !any_req));
   assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));
   assert_grant_has_req_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((grant & ~$past(req)) == '0));
   assert_flag_match_R5: assert property (@(posedge clk) disable iff (rst)
      any_req == ($countones(grant) == 1));
   assert_flag_req_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (any_req == ($past(req) != '0)));
endmodule

// File: tb/tb_cas_prio_grant.sv
module tb_cas_prio_grant;
   localparam int GROUPS = 8;
   localparam int W = 4 * GROUPS;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] req;
   logic [W-1:0] grant;
   logic         any_req;
   int n_cmp = 0;
   int n_bad = 0;
   logic [W-1:0] exp_q [$];

   always #5 clk = ~clk;

   cas_prio_grant #(.GROUPS(GROUPS)) dut (
      .clk(clk), .rst(rst), .req(req), .grant(grant), .any_req(any_req)
   );

   function automatic logic [W-1:0] model(input logic [W-1:0] r);
      for (int i = 0; i < W; i++)
         if (r[i]) return (W'(1) << i);
      return '0;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] eg, input logic ea);
      n_cmp++;
      if (grant !== eg || any_req !== ea) begin
         n_bad++;
         $display("FAIL %s: grant=%h any=%b expected grant=%h any=%b", tag, grant, any_req, eg, ea);
      end
   endtask

   // apply a request, step one clock, compare against the model away from the edge
   task automatic step(input string tag, input logic [W-1:0] r);
      logic [W-1:0] e;
      req = r;
      exp_q.push_back(model(r));
      @(posedge clk); #2;
      e = exp_q.pop_front();
      check(tag, e, (r != '0));
   endtask

   initial begin
      #1500000;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1; req = '1;
      @(posedge clk); #2;
      check("R1 reset", '0, 1'b0);
      @(posedge clk); #2;
      check("R1 reset held", '0, 1'b0);
      rst = 1'b0;
      step("R2 R5 all-zero", '0);
      step("R2 R6 all-ones", '1);
      for (int i = 0; i < W; i++) step("R2 R4 single bit", W'(1) << i);
      // a lower group masks every higher group
      for (int g = 0; g < GROUPS; g++) step("R6 group mask", ~((W'(1) << (4*g)) - 1));
      // later bits inside a group lose to the first one
      for (int g = 0; g < GROUPS; g++) step("R6 in-group", W'(4'b1110) << (4*g));
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] r;
         r = W'($urandom) & W'($urandom) & W'($urandom);
         if (i % 2 == 1) r = W'($urandom);
         step("R2 R3 R7 random", r);
      end
      req = '1; rst = 1'b1;
      @(posedge clk); #2;
      check("R1 reset mid-run", '0, 1'b0);
      rst = 1'b0;
      step("R2 after reset", W'(32'h0000_0100));
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule